// File: doc/BRIEF.md
# High-Side Load Switch Fault Supervisor

This block sits between a PWM control input and the gate-enable of an external high-side load switch. It watches two comparator flags that the analog front end has already turned into logic levels: one says the switch is regulating its current at the limit, the other says the load current is too small, which points to an open load. All of its timing runs off a one-pulse-per-microsecond tick enable, so the interval and threshold parameters below are counted in ticks.

The current-limit flag is sampled once per sample interval. An up/down accumulator counts one up on each sample that finds the switch in current limit and one down, never below zero, on each sample that does not, so that it follows the net time spent in limit. When it reaches the trip count the switch is shut off and stays off until a clear pulse arrives. The open-load flag passes through a blanking filter that only runs while the PWM input is high and past a short settle window after each rising edge. Both faults show up as sticky status outputs.

Top module: `hsw_fault_supervisor`

## Requirements
- R1: While reset is high and on the first cycle after it, gate_en, ilim_shutdown and open_load are all 0.
- R2: While no shutdown is latched, gate_en equals the value pwm_in had on the previous clock edge.
- R3: A sample point occurs on every SAMPLE_TICKS-th tick since reset. At a sample point, when no shutdown is latched, the accumulator increments if ilim_flag is 1 and decrements by one, staying at zero, if it is 0.
- R4: At the sample point where the accumulator would reach LIMIT_SAMPLES, ilim_shutdown goes to 1 and gate_en goes to 0 at that same clock edge.
- R5: Once set, ilim_shutdown stays 1 and gate_en stays 0 regardless of pwm_in until fault_clr is 1. The accumulator holds its value meanwhile.
- R6: A cycle with fault_clr = 1 clears ilim_shutdown, open_load, the accumulator and the open-load blanking count at the next edge. The clear takes priority over a fault set in the same cycle.
- R7: A rising edge of pwm_in opens a settle window of SETTLE_TICKS ticks. Open-load blanking does not count during that window, on the rising-edge cycle itself, or while pwm_in is 0.
- R8: open_load is set after the open-load flag has been 1 at BLANK_TICKS consecutive qualifying ticks. Any cycle that does not qualify sets the blanking count back to zero.
- R9: open_load is sticky until fault_clr and has no effect on gate_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle timebase enable, nominally 1 MHz |
| pwm_in | input | 1 | PWM control level for the switch |
| ilim_flag | input | 1 | Current-limit comparator output |
| oload_flag | input | 1 | Open-load comparator output |
| fault_clr | input | 1 | Clear pulse for the latched faults |
| gate_en | output | 1 | Registered gate enable to the switch driver |
| ilim_shutdown | output | 1 | Sticky current-limit shutdown status |
| open_load | output | 1 | Sticky open-load status |

## Verification
The checker verifies on every cycle that a latched shutdown forces the gate off, that the gate follows the delayed PWM level otherwise, that both fault bits are sticky and are cleared by a clear pulse, and that each fault can only rise with its own flag active. How many samples it takes to trip, how the accumulator saturates at zero, how long the settle window lasts and how long open-load blanking takes are counts over many cycles. Those are shown only by the bench scenarios, which compare the outputs against a tick-level model of the requirements while the current-limit duty and the PWM timing vary.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  // Accumulator operation chosen at a sample point
  typedef enum logic [1:0] {
    ACC_HOLD = 2'd0,
    ACC_UP   = 2'd1,
    ACC_DOWN = 2'd2
  } acc_op_e;

  // Fault status pair as seen at the block's outputs
  typedef struct packed {
    logic ilim_trip;
    logic oload;
  } hsw_status_t;
endpackage

// File: rtl/hsw_sample_timer.sv
module hsw_sample_timer #(
  parameter int SAMPLE_TICKS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic sample_stb
);
  localparam int CW = (SAMPLE_TICKS > 1) ? $clog2(SAMPLE_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLE_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign sample_stb = tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hsw_ilim_accum.sv
module hsw_ilim_accum
  import hsw_pkg::*;
#(
  parameter int LIMIT_SAMPLES = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_stb,
  input  logic ilim_flag,
  input  logic clr,
  output logic trip_q,
  output logic trip_nxt
);
  localparam int AW = $clog2(LIMIT_SAMPLES + 1);
  localparam logic [AW-1:0] TOP = AW'(LIMIT_SAMPLES - 1);

  logic [AW-1:0] acc_q;
  acc_op_e       op;
  logic          reach;

  always_comb begin
    op = ACC_HOLD;
    if (sample_stb && !trip_q) begin
      if (ilim_flag)          op = ACC_UP;
      else if (acc_q != '0)   op = ACC_DOWN;
    end
  end

  assign reach    = (op == ACC_UP) && (acc_q == TOP);
  assign trip_nxt = !clr && (trip_q || reach);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      trip_q <= trip_nxt;
      case (op)
        ACC_UP:   acc_q <= acc_q + 1'b1;
        ACC_DOWN: acc_q <= acc_q - 1'b1;
        default:  acc_q <= acc_q;
      endcase
    end
  end
endmodule

// File: rtl/hsw_oload_filter.sv
module hsw_oload_filter #(
  parameter int SETTLE_TICKS = 30,
  parameter int BLANK_TICKS  = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pwm_in,
  input  logic oload_flag,
  input  logic clr,
  output logic oload_q
);
  localparam int SW = $clog2(SETTLE_TICKS + 1);
  localparam int BW = (BLANK_TICKS > 1) ? $clog2(BLANK_TICKS) : 1;
  localparam logic [SW-1:0] SETTLE_LOAD = SW'(SETTLE_TICKS);
  localparam logic [BW-1:0] BLANK_LAST  = BW'(BLANK_TICKS - 1);

  logic          pwm_q;
  logic [SW-1:0] settle_q;
  logic [BW-1:0] blank_q;
  logic          rise, qualify;

  assign rise    = pwm_in && !pwm_q;
  assign qualify = pwm_in && !rise && (settle_q == '0) && oload_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q    <= 1'b0;
      settle_q <= '0;
    end else begin
      pwm_q <= pwm_in;
      if (rise)                         settle_q <= SETTLE_LOAD;
      else if (tick && settle_q != '0)  settle_q <= settle_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      blank_q <= '0;
      oload_q <= 1'b0;
    end else if (!qualify) begin
      blank_q <= '0;
    end else if (tick) begin
      if (blank_q == BLANK_LAST) oload_q <= 1'b1;
      else                       blank_q <= blank_q + 1'b1;
    end
  end
endmodule

// File: rtl/hsw_fault_supervisor.sv
module hsw_fault_supervisor
  import hsw_pkg::*;
#(
  parameter int SAMPLE_TICKS  = 100,
  parameter int LIMIT_SAMPLES = 50,
  parameter int BLANK_TICKS   = 100,
  parameter int SETTLE_TICKS  = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic pwm_in,
  input  logic ilim_flag,
  input  logic oload_flag,
  input  logic fault_clr,
  output logic gate_en,
  output logic ilim_shutdown,
  output logic open_load
);
  logic        sample_stb;
  logic        trip_q, trip_nxt, oload_q;
  hsw_status_t status;

  hsw_sample_timer #(.SAMPLE_TICKS(SAMPLE_TICKS)) u_timer (
    .clk(clk), .rst(rst), .tick(tick_us), .sample_stb(sample_stb)
  );

  hsw_ilim_accum #(.LIMIT_SAMPLES(LIMIT_SAMPLES)) u_accum (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .ilim_flag(ilim_flag),
    .clr(fault_clr), .trip_q(trip_q), .trip_nxt(trip_nxt)
  );

  hsw_oload_filter #(.SETTLE_TICKS(SETTLE_TICKS), .BLANK_TICKS(BLANK_TICKS)) u_oload (
    .clk(clk), .rst(rst), .tick(tick_us), .pwm_in(pwm_in),
    .oload_flag(oload_flag), .clr(fault_clr), .oload_q(oload_q)
  );

  always_ff @(posedge clk) begin
    if (rst) gate_en <= 1'b0;
    else     gate_en <= pwm_in && !trip_nxt;
  end

  assign status.ilim_trip = trip_q;
  assign status.oload     = oload_q;
  assign ilim_shutdown    = status.ilim_trip;
  assign open_load        = status.oload;
endmodule

// File: rtl/hsw_fault_supervisor_chk.sv
module hsw_fault_supervisor_chk (
  input logic clk,
  input logic rst,
  input logic tick_us,
  input logic pwm_in,
  input logic ilim_flag,
  input logic oload_flag,
  input logic fault_clr,
  input logic gate_en,
  input logic ilim_shutdown,
  input logic open_load
);
  logic was_rst;
  always_ff @(posedge clk) was_rst <= rst;

  // R5
  gate_off_when_tripped_chk: assert property (@(posedge clk) disable iff (rst)
    ilim_shutdown |-> !gate_en);

  // R2
  gate_follows_pwm_chk: assert property (@(posedge clk) disable iff (rst)
    (!was_rst && !ilim_shutdown) |-> (gate_en == $past(pwm_in)));

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    fault_clr |=> (!ilim_shutdown && !open_load));

  // R5
  trip_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ilim_shutdown && !fault_clr) |=> ilim_shutdown);

  // R9
  oload_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (open_load && !fault_clr) |=> open_load);

  // R4
  trip_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ilim_shutdown) |-> ($past(ilim_flag) && $past(tick_us)));

  // R8
  oload_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(open_load) |-> ($past(oload_flag) && $past(pwm_in) && $past(tick_us)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    was_rst |-> (!gate_en && !ilim_shutdown && !open_load));
endmodule

bind hsw_fault_supervisor hsw_fault_supervisor_chk u_chk (.*);

// File: tb/tb_hsw_fault_supervisor.sv
module tb_hsw_fault_supervisor;
  localparam int S_T = 10;
  localparam int L_S = 8;
  localparam int B_T = 12;
  localparam int W_T = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_us = 1'b0, pwm_in = 1'b0, ilim_flag = 1'b0, oload_flag = 1'b0, fault_clr = 1'b0;
  logic gate_en, ilim_shutdown, open_load;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hsw_fault_supervisor #(.SAMPLE_TICKS(S_T), .LIMIT_SAMPLES(L_S),
                         .BLANK_TICKS(B_T), .SETTLE_TICKS(W_T)) dut (
    .clk(clk), .rst(rst), .tick_us(tick_us), .pwm_in(pwm_in), .ilim_flag(ilim_flag),
    .oload_flag(oload_flag), .fault_clr(fault_clr), .gate_en(gate_en),
    .ilim_shutdown(ilim_shutdown), .open_load(open_load));

  // Tick-level model written from the requirements
  int m_scnt, m_acc, m_settle, m_blank;
  bit m_trip, m_gate, m_ol, m_pq;

  function automatic bit next_trip(bit trip, int acc, bit smp, bit il, bit clr);
    if (clr) return 0;
    return trip || (smp && il && acc == L_S - 1);
  endfunction

  always @(posedge clk) begin
    bit smp, rise, qual, nt;
    if (rst) begin
      m_scnt <= 0; m_acc <= 0; m_settle <= 0; m_blank <= 0;
      m_trip <= 0; m_gate <= 0; m_ol <= 0; m_pq <= 0;
    end else begin
      smp  = tick_us && (m_scnt == S_T - 1);
      nt   = next_trip(m_trip, m_acc, smp && !m_trip, ilim_flag, fault_clr);
      rise = pwm_in && !m_pq;
      qual = pwm_in && !rise && (m_settle == 0) && oload_flag;
      if (tick_us) m_scnt <= (m_scnt == S_T - 1) ? 0 : m_scnt + 1;
      m_trip <= nt;
      m_gate <= pwm_in && !nt;
      if (fault_clr) m_acc <= 0;
      else if (smp && !m_trip) m_acc <= ilim_flag ? m_acc + 1 : (m_acc > 0 ? m_acc - 1 : 0);
      m_pq <= pwm_in;
      if (rise) m_settle <= W_T;
      else if (tick_us && m_settle > 0) m_settle <= m_settle - 1;
      if (fault_clr) begin m_blank <= 0; m_ol <= 0; end
      else if (!qual) m_blank <= 0;
      else if (tick_us) begin
        if (m_blank == B_T - 1) m_ol <= 1; else m_blank <= m_blank + 1;
      end
    end
  end

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  // One clock: compare at the falling edge, then drive the next inputs
  task automatic step(input bit p, input bit il, input bit ol, input bit clr);
    @(negedge clk);
    if (!rst) begin
      check(gate_en, m_gate, "R2/R4/R5 gate_en");
      check(ilim_shutdown, m_trip, "R3/R4/R6 ilim_shutdown");
      check(open_load, m_ol, "R7/R8/R9 open_load");
    end
    pwm_in = p; ilim_flag = il; oload_flag = ol; fault_clr = clr;
    tick_us = ~tick_us;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    // R1: outputs quiet in reset
    check(gate_en, 0, "R1 gate_en"); check(ilim_shutdown, 0, "R1 ilim_shutdown");
    check(open_load, 0, "R1 open_load");
    @(negedge clk); rst = 0;
    step(0, 0, 0, 0);
    check(gate_en, 0, "R1 gate_en after reset");

    // Directed R4: continuous limit trips after L_S samples
    step(1, 1, 0, 1);
    repeat ((L_S + 1) * S_T * 2 + 4) step(1, 1, 0, 0);
    check(ilim_shutdown, 1, "R4 trip after continuous limit");
    check(gate_en, 0, "R4 gate off at trip");
    // R5: PWM toggling has no effect while latched
    for (int i = 0; i < 6; i++) begin
      step(i[0], 0, 0, 0);
      check(gate_en, 0, "R5 gate held low");
      check(ilim_shutdown, 1, "R5 shutdown held");
    end
    // R6: clear with the limit still asserted
    step(1, 1, 0, 1);
    step(1, 0, 0, 0);
    check(ilim_shutdown, 0, "R6 shutdown cleared");
    check(gate_en, 1, "R2 gate follows pwm after clear");

    // Directed R7/R8: settle window then blanking
    repeat (4) step(0, 0, 0, 0);
    step(1, 0, 1, 0);
    repeat ((W_T + B_T - 3) * 2) step(1, 0, 1, 0);
    check(open_load, 0, "R7 no report inside settle+blank");
    repeat (12) step(1, 0, 1, 0);
    check(open_load, 1, "R8 open load after blanking");
    check(gate_en, 1, "R9 open load leaves gate on");
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    check(open_load, 1, "R9 open load sticky");
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    check(open_load, 0, "R6 open load cleared");

    // Random phases with varying limit duty
    for (int ph = 0; ph < 12; ph++) begin
      int duty = 20 + ph * 7;
      int ol_pct = $urandom_range(0, 100);
      bit p = 0, o = 0;
      int left = 0;
      for (int c = 0; c < 1500; c++) begin
        if (left == 0) begin p = ~p; left = $urandom_range(8, 160); end
        left--;
        if ($urandom_range(0, 19) == 0) o = ($urandom_range(0, 99) < ol_pct);
        step(p, $urandom_range(0, 99) < duty, o, $urandom_range(0, 599) == 0);
      end
    end
    step(0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule